// File: doc/BRIEF.md
# Tile-Fetch Driven Pattern Bank Selector

This block watches the graphics address bus and keeps one selector flag for each 4 KB pattern half. The lower half covers addresses with bit 12 clear, and the upper half covers addresses with bit 12 set. Certain tile addresses act as triggers. When a fetch reaches one of them, the flag for that half takes its new value from address bit 5. No processor write is involved: the rendering fetches themselves switch the bank choice. Downstream logic uses the flags to decide which bank register feeds each half.

Each flag is a two-state machine. The states are `SEL_A` (flag 0, reached from a trigger whose bit 5 is 0) and `SEL_B` (flag 1, reached from a trigger whose bit 5 is 1). The transitions are named as follows:
- `TAKE_B` goes from `SEL_A` to `SEL_B` on a trigger hit with bit 5 = 1.
- `TAKE_A` goes from `SEL_B` to `SEL_A` on a trigger hit with bit 5 = 0.
- `KEEP` holds the current state in every other case.

A combined select output passes on the flag of the half that the current address falls in. It follows the address without a register, so a switch applies from the fetch after the trigger fetch.

Top module: `chr_fetch_latch`

## Requirements
- R1: While `rst_n` is low, both flags are 0 (`SEL_A`). After reset is released, `bank_sel` is 0 until a trigger fetch occurs.
- R2: A fetch with `vaddr` in 0x0FD8–0x0FDF sets `flag_lo` to 0 at the next rising clock edge. A fetch in 0x0FE8–0x0FEF sets `flag_lo` to 1.
- R3: A fetch with `vaddr` in 0x1FD8–0x1FDF sets `flag_hi` to 0 at the next rising clock edge. A fetch in 0x1FE8–0x1FEF sets `flag_hi` to 1.
- R4: Address bits 2:0 have no effect on whether an address triggers.
- R5: An address that differs from a trigger pattern in any of bits 13:6 or 4:3 leaves both flags unchanged. Examples are 0x0FF8, 0x0FE0, 0x2FE8 and 0x0EE8.
- R6: When `fetch_strobe` is low, no flag changes, whatever the address.
- R7: `bank_sel` equals `flag_lo` when `vaddr[12]` is 0 and `flag_hi` when `vaddr[12]` is 1. It follows the address within the same cycle.
- R8: A trigger in one half never changes the flag of the other half.
- R9: During the trigger fetch's own cycle, `bank_sel` still shows the old flag. The new value appears only after the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vaddr | input | 14 | Graphics-side address of the current fetch |
| fetch_strobe | input | 1 | High when `vaddr` carries a valid fetch |
| flag_lo | output | 1 | Selector flag for the lower pattern half |
| flag_hi | output | 1 | Selector flag for the upper pattern half |
| bank_sel | output | 1 | Flag of the half addressed by `vaddr[12]` |

## Verification
A flag stuck in the wrong state shows up on `bank_sel` as soon as an address in that half is presented, in the same cycle with no delay. It shows directly on `flag_lo` or `flag_hi` one edge after the fetch that caused it. A decoder that is too loose or too tight shows up one edge after a near-miss or a boundary address. The vectors therefore pair each trigger with neighbours that differ in a single bit. They also check that the opposite half's flag stayed put.

// File: rtl/chr_latch_pkg.sv
package chr_latch_pkg;

    // Address bus geometry
    localparam int unsigned ADDR_W    = 14;
    localparam int unsigned HALF_BIT  = 12;
    localparam int unsigned VALUE_BIT = 5;
    localparam int unsigned IGN_BITS  = 3;
    localparam int unsigned N_HALVES  = 2;

    // Bits that take part in the trigger compare (low IGN_BITS ignored)
    localparam logic [ADDR_W-1:0] TRIG_MASK = {{(ADDR_W-IGN_BITS){1'b1}}, {IGN_BITS{1'b0}}};

    typedef enum logic [0:0] {
        SEL_A = 1'b0,
        SEL_B = 1'b1
    } half_state_e;

    // Trigger pattern: bit13=0, bit12=half, bits11:6 all ones,
    // bits5:3 = {val, ~val, 1}, bits2:0 zero (masked out anyway)
    function automatic logic [ADDR_W-1:0] trig_pattern(input logic half, input logic val);
        trig_pattern = {1'b0, half, 6'b111111, val, ~val, 1'b1, 3'b000};
    endfunction

    function automatic logic addr_hits(input logic [ADDR_W-1:0] a, input logic half);
        logic [ADDR_W-1:0] m;
        m = a & TRIG_MASK;
        addr_hits = (m == trig_pattern(half, 1'b0)) || (m == trig_pattern(half, 1'b1));
    endfunction

endpackage

// File: rtl/chr_tile_match.sv
module chr_tile_match
    import chr_latch_pkg::*;
#(
    parameter int unsigned HALF = 0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              fetch,
    output logic              hit,
    output logic              val
);

    localparam logic HALF_L = HALF[0];
    localparam logic [ADDR_W-1:0] PAT_A = trig_pattern(HALF_L, 1'b0);
    localparam logic [ADDR_W-1:0] PAT_B = trig_pattern(HALF_L, 1'b1);

    logic [ADDR_W-1:0] masked;

    always_comb begin
        masked = addr & TRIG_MASK;
        hit    = fetch && ((masked == PAT_A) || (masked == PAT_B));
        val    = addr[VALUE_BIT];
    end

endmodule

// File: rtl/chr_half_fsm.sv
module chr_half_fsm
    import chr_latch_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic val,
    output logic flag
);

    half_state_e state_q;
    half_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEL_A;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: TAKE_B, TAKE_A, otherwise KEEP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEL_A: if (hit && val)  state_d = SEL_B;
            SEL_B: if (hit && !val) state_d = SEL_A;
            default: state_d = SEL_A;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            SEL_B:   flag = 1'b1;
            default: flag = 1'b0;
        endcase
    end

endmodule

// File: rtl/chr_sel_mux.sv
module chr_sel_mux
    import chr_latch_pkg::*;
(
    input  logic [N_HALVES-1:0] flags,
    input  logic                half,
    output logic                sel
);

    always_comb begin
        sel = flags[half];
    end

endmodule

// File: rtl/chr_fetch_latch.sv
module chr_fetch_latch
    import chr_latch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] vaddr,
    input  logic              fetch_strobe,
    output logic              flag_lo,
    output logic              flag_hi,
    output logic              bank_sel
);

    logic [N_HALVES-1:0] hits;
    logic [N_HALVES-1:0] vals;
    logic [N_HALVES-1:0] flags;

    for (genvar h = 0; h < N_HALVES; h++) begin : g_half
        chr_tile_match #(.HALF(h)) match_i (
            .addr  (vaddr),
            .fetch (fetch_strobe),
            .hit   (hits[h]),
            .val   (vals[h])
        );

        chr_half_fsm fsm_i (
            .clk   (clk),
            .rst_n (rst_n),
            .hit   (hits[h]),
            .val   (vals[h]),
            .flag  (flags[h])
        );
    end

    chr_sel_mux mux_i (
        .flags (flags),
        .half  (vaddr[HALF_BIT]),
        .sel   (bank_sel)
    );

    assign flag_lo = flags[0];
    assign flag_hi = flags[1];

endmodule

// File: rtl/chr_fetch_latch_chk.sv
module chr_fetch_latch_chk
    import chr_latch_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] vaddr,
    input logic              fetch_strobe,
    input logic              flag_lo,
    input logic              flag_hi
);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |-> (!flag_lo && !flag_hi));

    p_lo_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_strobe && addr_hits(vaddr, 1'b0)) |=> (flag_lo == $past(vaddr[VALUE_BIT])));

    p_hi_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_strobe && addr_hits(vaddr, 1'b1)) |=> (flag_hi == $past(vaddr[VALUE_BIT])));

    p_lo_miss_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_strobe && !addr_hits(vaddr, 1'b0) && !addr_hits(vaddr, 1'b1))
        |=> ($stable(flag_lo) && $stable(flag_hi)));

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_strobe |=> ($stable(flag_lo) && $stable(flag_hi)));

    p_lo_untouched_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_strobe && addr_hits(vaddr, 1'b1)) |=> $stable(flag_lo));

    p_hi_untouched_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_strobe && addr_hits(vaddr, 1'b0)) |=> $stable(flag_hi));

endmodule

bind chr_fetch_latch chr_fetch_latch_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .vaddr        (vaddr),
    .fetch_strobe (fetch_strobe),
    .flag_lo      (flag_lo),
    .flag_hi      (flag_hi)
);

// File: tb/chr_fetch_latch_tb_top.sv
`timescale 1ns/1ps
module chr_fetch_latch_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] vaddr = '0;
    logic        fetch_strobe = 1'b0;
    logic        flag_lo;
    logic        flag_hi;
    logic        bank_sel;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    chr_fetch_latch dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .vaddr        (vaddr),
        .fetch_strobe (fetch_strobe),
        .flag_lo      (flag_lo),
        .flag_hi      (flag_hi),
        .bank_sel     (bank_sel)
    );

    // Vector: [16:3] address, [2] strobe, [1] expected flag_lo, [0] expected flag_hi
    localparam int NV = 14;
    localparam logic [16:0] VEC [NV] = '{
        {14'h0FE8, 1'b1, 1'b1, 1'b0},  // R2 lower FE -> 1
        {14'h1FEF, 1'b1, 1'b1, 1'b1},  // R3 R4 upper FE, low bits set
        {14'h0FDB, 1'b0, 1'b1, 1'b1},  // R6 no strobe
        {14'h0FDB, 1'b1, 1'b0, 1'b1},  // R2 R4 lower FD -> 0
        {14'h0FF8, 1'b1, 1'b0, 1'b1},  // R5 bits 4:3 differ
        {14'h0FE0, 1'b1, 1'b0, 1'b1},  // R5 bit 3 clear
        {14'h2FE8, 1'b1, 1'b0, 1'b1},  // R5 bit 13 set
        {14'h0EE8, 1'b1, 1'b0, 1'b1},  // R5 bit 8 clear
        {14'h0FC8, 1'b1, 1'b0, 1'b1},  // R5 bits 5:3 = 001
        {14'h1FD8, 1'b1, 1'b0, 1'b0},  // R3 upper FD -> 0
        {14'h0FEC, 1'b1, 1'b1, 1'b0},  // R8 lower trigger, upper kept
        {14'h1FE9, 1'b0, 1'b1, 1'b0},  // R6 no strobe
        {14'h1FE9, 1'b1, 1'b1, 1'b1},  // R3 R8 upper trigger, lower kept
        {14'h0FDF, 1'b1, 1'b0, 1'b1}   // R2 R4 top of FD range
    };

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic step(input logic [13:0] a, input logic f);
        @(negedge clk);
        vaddr        = a;
        fetch_strobe = f;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        // R1: reset state
        #12;
        check("R1 flag_lo in reset", flag_lo, 1'b0);
        check("R1 flag_hi in reset", flag_hi, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        vaddr = 14'h1000;
        #1;
        check("R1 bank_sel after reset", bank_sel, 1'b0);

        // Table walk (R2 R3 R4 R5 R6 R8)
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][16:3], VEC[i][2]);
            check($sformatf("vector %0d flag_lo", i), flag_lo, VEC[i][1]);
            check($sformatf("vector %0d flag_hi", i), flag_hi, VEC[i][0]);
        end

        // R7: flags now lo=0 hi=1; select follows bit 12 combinationally
        @(negedge clk);
        fetch_strobe = 1'b0;
        vaddr = 14'h0123;
        #1;
        check("R7 sel lower", bank_sel, 1'b0);
        vaddr = 14'h1123;
        #1;
        check("R7 sel upper", bank_sel, 1'b1);

        // R9: trigger cycle still shows old flag
        @(negedge clk);
        vaddr = 14'h0FE8;
        fetch_strobe = 1'b1;
        #1;
        check("R9 sel during trigger", bank_sel, 1'b0);
        @(posedge clk);
        #1;
        check("R9 sel after edge", bank_sel, 1'b1);
        @(negedge clk);
        fetch_strobe = 1'b0;

        // R1: reset mid-run clears both flags
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 flag_lo after mid reset", flag_lo, 1'b0);
        check("R1 flag_hi after mid reset", flag_hi, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule